// File: doc/BRIEF.md
# Paired-Channel Pulse-Width Modulator Bank

The block drives eight pulse-width modulated outputs. Each output has its own 8-bit period and duty registers, an active-level bit, a choice between edge-aligned (count up and wrap) and center-aligned (count up, then back down) counting, and a clock-rate select. The clock-rate select picks one of eight tick rates from a shared power-of-two divider. Neighbouring channels can be fused in pairs. A fused pair becomes one 16-bit channel: the even channel supplies the low byte of period and duty, and the odd channel supplies the high byte, the mode bits, the enable and the output pin.

Software programs the block through a single-cycle write port and starts or stops each channel with a level-sensitive enable vector. Period and duty writes land in working registers. A running channel copies them into its counting logic only when a period ends, so a write mid-period never produces a truncated or stretched pulse.

Top module: `pwm_bank`

## Requirements
- R1: After reset every channel has period 0, duty 0, active-high polarity, edge-aligned mode, clock select 0 and no pairs fused, and every output reads 0.
- R2: Address layout: when the top address bit is 0, bits [4:2] pick the channel and bits [1:0] pick the field: 0 = period, 1 = duty, 2 = control. In the control byte, bit 0 = 1 means active high, bit 1 = 1 means center-aligned, and bits [4:2] are the clock select. A channel whose enable is low drives its inactive level and restarts its count from 0 when enabled.
- R3: In edge-aligned mode with 0 < duty < period, the output repeats every period ticks and is active for duty ticks of each repetition.
- R4: In center-aligned mode with 0 < duty < period, the output repeats every 2 x period ticks and is active for 2 x duty ticks of each repetition.
- R5: A duty of 0 keeps the output at the inactive level in both modes.
- R6: A duty equal to or greater than the period keeps the output at the active level in both modes.
- R7: The polarity bit selects the active level: 1 = active high, 0 = active low.
- R8: Clock select s makes the channel advance once every 2^s clock cycles, which scales the period and the active time by 2^s.
- R9: A period or duty write to a running channel takes effect only from the next period boundary; the period in progress finishes with the old values.
- R10: Address 0x20 is the pair register; bit p fuses channels 2p and 2p+1. In a fused pair, the values are {odd byte, even byte}, the odd channel's control byte and enable govern it, the result drives the odd output, the even enable is ignored and the even output stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register address |
| wr_data | input | 8 | Register write data |
| ch_en | input | 8 | Per-channel run enable |
| pwm_out | output | 8 | Modulated outputs |

## Verification
The bench goes after the duty extremes. A design that compared duty against the count without clamping would emit a one-tick blip in center mode when duty equals the period, and one that mishandled duty 0 would leave a sliver of active time. It rewrites the duty partway through a period. An unbuffered design would then change the pulse in the current period rather than the next one. It fuses a pair while the even enable is low and then high. A design that let the even channel keep running, or that built the 16-bit value with the bytes swapped, would show activity on the even pin or a wrong active count. Center-aligned vectors under a prescaler catch an off-by-one at the turnaround, which would give 2 x duty - 1 active ticks instead of 2 x duty.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int CH_W   = 8;
    localparam int SEL_W  = 3;
    localparam int NSRC   = 1 << SEL_W;

    typedef enum logic [1:0] {
        FLD_PERIOD = 2'd0,
        FLD_DUTY   = 2'd1,
        FLD_CTRL   = 2'd2,
        FLD_SPARE  = 2'd3
    } field_e;

    typedef struct packed {
        logic [CH_W-1:0]  period;
        logic [CH_W-1:0]  duty;
        logic             pol;
        logic             center;
        logic [SEL_W-1:0] sel;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{
        period: '0, duty: '0, pol: 1'b1, center: 1'b0, sel: '0
    };

    function automatic logic drive_level(input logic active, input logic pol);
        return active ? pol : ~pol;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_bank_pkg::*;
#(
    parameter int NS = NSRC
) (
    input  logic          clk,
    input  logic          rst,
    output logic [NS-1:0] tick
);
    logic [NS-2:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    assign tick[0] = 1'b1;

    generate
        for (genvar k = 1; k < NS; k++) begin : g_tap
            assign tick[k] = &div_q[k-1:0];
        end
    endgenerate

    // R8: a divided tick never lasts two cycles in a row
    a_r8_tick_single: assert property (@(posedge clk) disable iff (rst)
        tick[1] |=> !tick[1]);

endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_bank_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [CH_W-1:0]         wr_data,
    output chan_cfg_t [NCH-1:0]     cfg,
    output logic [NCH/2-1:0]        join_q
);
    localparam int IDX_W = $clog2(NCH);
    localparam int NPAIR = NCH / 2;

    logic             is_global;
    logic [IDX_W-1:0] idx;
    field_e           fld;

    assign is_global = wr_addr[ADDR_W-1];
    assign idx       = wr_addr[IDX_W+1:2];
    assign fld       = field_e'(wr_addr[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) cfg[i] <= CFG_RESET;
            join_q <= '0;
        end else if (wr_en) begin
            if (is_global) begin
                join_q <= wr_data[NPAIR-1:0];
            end else begin
                case (fld)
                    FLD_PERIOD: cfg[idx].period <= wr_data;
                    FLD_DUTY:   cfg[idx].duty   <= wr_data;
                    FLD_CTRL: begin
                        cfg[idx].pol    <= wr_data[0];
                        cfg[idx].center <= wr_data[1];
                        cfg[idx].sel    <= wr_data[2 +: SEL_W];
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_bank_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         tick,
    input  logic [W-1:0] period,
    input  logic [W-1:0] duty,
    input  logic         pol,
    input  logic         center,
    output logic         pwm_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] sh_p;
    logic [W-1:0] sh_d;
    logic         sh_c;
    logic         down_q;
    logic         at_end;
    logic         active;

    always_comb begin
        if (sh_p == '0)  at_end = 1'b1;
        else if (sh_c)   at_end = down_q && (cnt_q == W'(1));
        else             at_end = (cnt_q == sh_p - W'(1));
    end

    always_comb begin
        if (sh_d == '0)        active = 1'b0;
        else if (sh_d >= sh_p) active = 1'b1;
        else if (down_q)       active = (cnt_q <= sh_d);
        else                   active = (cnt_q <  sh_d);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
            sh_p   <= period;
            sh_d   <= duty;
            sh_c   <= center;
        end else if (tick) begin
            if (at_end) begin
                cnt_q  <= '0;
                down_q <= 1'b0;
                sh_p   <= period;
                sh_d   <= duty;
                sh_c   <= center;
            end else if (!sh_c || !down_q) begin
                cnt_q <= cnt_q + W'(1);
                if (sh_c && (cnt_q + W'(1) == sh_p)) down_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - W'(1);
            end
        end
    end

    assign pwm_o = en ? drive_level(active, pol) : ~pol;

    // R3 / R4: count stays inside the latched period
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (en && sh_p != '0) |-> (sh_c ? (cnt_q <= sh_p) : (cnt_q < sh_p)));

    // R9: latched values only move at a period boundary
    a_r9_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(rst) && !$past(tick && at_end))
        |-> ($stable(sh_d) && $stable(sh_p)));

    // R5: zero duty is never active
    a_r5_zero_duty: assert property (@(posedge clk) disable iff (rst)
        (en && sh_d == '0) |-> (pwm_o == ~pol));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter  int NCH    = 8,
    localparam int ADDR_W = $clog2(NCH) + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CH_W-1:0]   wr_data,
    input  logic [NCH-1:0]    ch_en,
    output logic [NCH-1:0]    pwm_out
);
    localparam int NPAIR = NCH / 2;

    logic [NSRC-1:0]      ticks;
    chan_cfg_t [NCH-1:0]  cfg;
    logic [NPAIR-1:0]     join_q;

    pwm_prescaler #(.NS(NSRC)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (ticks)
    );

    pwm_regfile #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg),
        .join_q  (join_q)
    );

    generate
        for (genvar p = 0; p < NPAIR; p++) begin : g_pair
            localparam int LO = 2 * p;
            localparam int HI = 2 * p + 1;

            logic joined;
            logic lo_o, hi_o, wide_o;

            assign joined = join_q[p];

            pwm_core #(.W(CH_W)) u_lo (
                .clk    (clk),
                .rst    (rst),
                .en     (ch_en[LO] && !joined),
                .tick   (ticks[cfg[LO].sel]),
                .period (cfg[LO].period),
                .duty   (cfg[LO].duty),
                .pol    (cfg[LO].pol),
                .center (cfg[LO].center),
                .pwm_o  (lo_o)
            );

            pwm_core #(.W(CH_W)) u_hi (
                .clk    (clk),
                .rst    (rst),
                .en     (ch_en[HI] && !joined),
                .tick   (ticks[cfg[HI].sel]),
                .period (cfg[HI].period),
                .duty   (cfg[HI].duty),
                .pol    (cfg[HI].pol),
                .center (cfg[HI].center),
                .pwm_o  (hi_o)
            );

            pwm_core #(.W(2 * CH_W)) u_wide (
                .clk    (clk),
                .rst    (rst),
                .en     (ch_en[HI] && joined),
                .tick   (ticks[cfg[HI].sel]),
                .period ({cfg[HI].period, cfg[LO].period}),
                .duty   ({cfg[HI].duty,   cfg[LO].duty}),
                .pol    (cfg[HI].pol),
                .center (cfg[HI].center),
                .pwm_o  (wide_o)
            );

            assign pwm_out[LO] = joined ? 1'b0   : lo_o;
            assign pwm_out[HI] = joined ? wide_o : hi_o;

            // R2: a stopped, unfused even channel sits at its inactive level
            a_r2_idle_level: assert property (@(posedge clk) disable iff (rst)
                (!joined && !ch_en[LO]) |-> (pwm_out[LO] == ~cfg[LO].pol));

            // R10: a fused pair with its odd enable low sits at the odd inactive level
            a_r10_pair_idle: assert property (@(posedge clk) disable iff (rst)
                (joined && !ch_en[HI]) |-> (pwm_out[HI] == ~cfg[HI].pol));
        end
    endgenerate

endmodule

// File: tb/pwm_bank_tb.sv
`timescale 1ns/1ps
module pwm_bank_tb_top;

    typedef struct packed {
        logic [2:0]  ch;
        logic [7:0]  per;
        logic [7:0]  duty;
        logic        pol;
        logic        ctr;
        logic [2:0]  sel;
        logic [15:0] exp_per;
        logic [15:0] exp_act;
    } vec_t;

    localparam int NV = 9;
    // exp_per = base period x 2^sel, base = period (edge) or 2 x period (center)
    localparam vec_t VECS [NV] = '{
        '{3'd0, 8'd10,  8'd3,   1'b1, 1'b0, 3'd0, 16'd10,  16'd3},   // R3 R7
        '{3'd3, 8'd10,  8'd3,   1'b0, 1'b0, 3'd0, 16'd10,  16'd3},   // R7 active low
        '{3'd5, 8'd6,   8'd2,   1'b1, 1'b1, 3'd0, 16'd12,  16'd4},   // R4
        '{3'd2, 8'd8,   8'd0,   1'b1, 1'b0, 3'd0, 16'd8,   16'd0},   // R5
        '{3'd7, 8'd8,   8'd8,   1'b1, 1'b0, 3'd0, 16'd8,   16'd8},   // R6 edge
        '{3'd6, 8'd5,   8'd9,   1'b1, 1'b1, 3'd0, 16'd10,  16'd10},  // R6 center
        '{3'd1, 8'd4,   8'd1,   1'b1, 1'b0, 3'd2, 16'd16,  16'd4},   // R8 edge
        '{3'd4, 8'd3,   8'd2,   1'b1, 1'b1, 3'd1, 16'd12,  16'd8},   // R8 center
        '{3'd0, 8'd255, 8'd128, 1'b1, 1'b0, 3'd0, 16'd255, 16'd128}  // R3 full range
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] ch_en = '0;
    logic [7:0] pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_bank dut_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ch_en   (ch_en),
        .pwm_out (pwm_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic meas(input int ch, input int skip, input int win,
                        input logic pol, output int act_cnt);
        repeat (skip) @(negedge clk);
        act_cnt = 0;
        repeat (win) begin
            @(negedge clk);
            if (pwm_out[ch] == pol) act_cnt++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int lo_hits;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(pwm_out == 8'h00, "R1 outputs after reset", pwm_out, 0);
        @(negedge clk) ch_en = 8'h01;
        meas(0, 0, 12, 1'b1, n);
        chk(n == 0, "R1 default duty is zero", n, 0);
        @(negedge clk) ch_en = 8'h00;

        // Vector table: R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            wr({1'b0, VECS[v].ch, 2'd0}, VECS[v].per);
            wr({1'b0, VECS[v].ch, 2'd1}, VECS[v].duty);
            wr({1'b0, VECS[v].ch, 2'd2}, {3'b000, VECS[v].sel, VECS[v].ctr, VECS[v].pol});
            @(negedge clk) ch_en = 8'h01 << VECS[v].ch;
            meas(int'(VECS[v].ch), int'(VECS[v].exp_per), 2 * int'(VECS[v].exp_per),
                 VECS[v].pol, n);
            chk(n == 2 * int'(VECS[v].exp_act),
                $sformatf("R3 R4 R5 R6 R7 R8 vector %0d active count", v),
                n, 2 * int'(VECS[v].exp_act));
            @(negedge clk) ch_en = 8'h00;
        end

        // R2: a stopped active-low channel idles high, others untouched
        wr({1'b0, 3'd3, 2'd2}, 8'h00);
        @(negedge clk);
        chk(pwm_out[3] == 1'b1, "R2 stopped active-low channel", pwm_out[3], 1);
        chk(pwm_out[2] == 1'b0, "R2 stopped active-high channel", pwm_out[2], 0);

        // R9: mid-period duty rewrite
        wr({1'b0, 3'd2, 2'd0}, 8'd10);
        wr({1'b0, 3'd2, 2'd1}, 8'd3);
        wr({1'b0, 3'd2, 2'd2}, 8'h01);
        @(negedge clk) ch_en = 8'h04;      // count 0 visible here
        wr({1'b0, 3'd2, 2'd1}, 8'd7);      // returns with count 2
        repeat (3) @(negedge clk);         // count 5, old duty 3
        chk(pwm_out[2] == 1'b0, "R9 old duty holds to period end", pwm_out[2], 0);
        repeat (10) @(negedge clk);        // count 5 of the next period, duty 7
        chk(pwm_out[2] == 1'b1, "R9 new duty after boundary", pwm_out[2], 1);
        @(negedge clk) ch_en = 8'h00;

        // R10: fuse pair 0, value 0x0102 / 0x0081
        wr({1'b0, 3'd0, 2'd0}, 8'h02);
        wr({1'b0, 3'd1, 2'd0}, 8'h01);
        wr({1'b0, 3'd0, 2'd1}, 8'h81);
        wr({1'b0, 3'd1, 2'd1}, 8'h00);
        wr({1'b0, 3'd0, 2'd2}, 8'h02);     // even control must be ignored
        wr({1'b0, 3'd1, 2'd2}, 8'h01);
        wr(6'h20, 8'h01);
        @(negedge clk) ch_en = 8'h01;      // even enable alone
        meas(1, 0, 20, 1'b1, n);
        chk(n == 0, "R10 even enable ignored", n, 0);
        chk(pwm_out[0] == 1'b0, "R10 even output low", pwm_out[0], 0);
        @(negedge clk) ch_en = 8'h03;
        repeat (258) @(negedge clk);
        n = 0;
        lo_hits = 0;
        for (int c = 0; c < 516; c++) begin
            @(negedge clk);
            if (pwm_out[1]) n++;
            if (pwm_out[0]) lo_hits++;
        end
        chk(n == 258, "R10 16-bit active count", n, 258);
        chk(lo_hits == 0, "R10 even pin quiet while fused", lo_hits, 0);
        @(negedge clk) ch_en = 8'h02;      // odd enable alone also runs the pair
        meas(1, 258, 516, 1'b1, n);
        chk(n == 258, "R10 odd enable governs pair", n, 258);
        @(negedge clk) ch_en = 8'h00;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule